// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers up to eight interrupt request lines. It holds them in a pending register, screens them through a mask, and ranks them against the levels already being served. It drives a single interrupt output toward a processor. When the processor strobes acknowledge, the controller marks the winning level as in service and returns an 8-bit vector. The vector is a programmable base in the upper five bits and the level number in the lower three.

Software sets the block up through byte-wide writes with one address bit. A setup sequence chooses edge or level sensing and the vector base, and may announce an extra word that the block swallows without effect. After setup, writes with the address bit high load the mask. Command writes with the address bit low end service of a level. There are several forms of end-of-service command. The non-specific form clears the top in-service level. The specific form names a level. The rotating forms also move the finished level to the bottom of the ranking, and a separate command moves any chosen level to the bottom. These rotating forms change the priority order while the block runs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, int_out is low and vec_out is 0. The mask is clear, no level is in service, sensing is edge, the vector base is 0, and the ranking is fixed with level 0 highest and level 7 lowest.
- R2: A write with addr0=0 and wr_data[4]=1 starts setup. wr_data[3] selects level sensing (1) or edge sensing (0). wr_data[0]=1 announces a fourth word. The write clears the mask, the in-service set and all pending requests, and restores the fixed ranking.
- R3: The first addr0=1 write after setup starts takes wr_data[7:3] as the vector base. Every vector is {base, level[2:0]}.
- R4: When a fourth word was announced, the next addr0=1 write is consumed with no effect. Otherwise, addr0=1 writes outside setup load the mask, where bit n = 1 blocks line n.
- R5: In edge mode, a low-to-high change on a line makes it pending one clock later. It stays pending after the line falls, until it is acknowledged. In level mode, pending follows the line one clock later.
- R6: int_out is high exactly when some unmasked pending line ranks strictly above every in-service level. A masked line never raises it.
- R7: An acknowledge strobe marks the highest-ranked unmasked pending line as in service, and vec_out carries its vector from the next cycle. With nothing pending, vec_out gives level 7 and no state changes.
- R8: Command writes use addr0=0 with wr_data[4:3]=00, the op code in wr_data[7:5] and a level in wr_data[2:0]. Op 001 (non-specific end) clears the highest-ranked in-service level.
- R9: Op 011 (specific end) clears the in-service bit of the level in wr_data[2:0].
- R10: Op 101 does what op 001 does and then makes the cleared level the lowest-ranked. Op 111 does what op 011 does and makes the named level the lowest-ranked. Op 110 makes the named level the lowest-ranked without touching the in-service set.
- R11: With level L lowest, the ranking runs L+1, L+2, ... cyclically modulo 8, so L+1 is highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| addr0 | input | 1 | Register select bit |
| wr_data | input | 8 | Write data byte |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | Acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |

## Verification
Every write, line change and acknowledge takes effect at the clock edge where it is presented. The result is due at the next clock edge, with no further delay: pending and in-service state, mask and ranking are all registered, and int_out follows them combinationally. vec_out is registered on the acknowledge edge. The bench drives each stimulus for exactly one clock and samples at the following falling edge, so each check lands in the first cycle where its result is due. A sweep over all eight bottom-ranked levels, each draining all eight requests, checks the order arithmetically as (L+1+k) mod 8.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   typedef enum logic [1:0] {
      CFG_READY      = 2'd0,
      CFG_WAIT_BASE  = 2'd1,
      CFG_WAIT_EXTRA = 2'd2
   } cfg_state_e;

   localparam logic [2:0] OP_END_TOP      = 3'b001;
   localparam logic [2:0] OP_END_NAMED    = 3'b011;
   localparam logic [2:0] OP_ROT_END_TOP  = 3'b101;
   localparam logic [2:0] OP_SET_BOTTOM   = 3'b110;
   localparam logic [2:0] OP_ROT_END_NAME = 3'b111;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         level_mode,
   input  logic         flush,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   logic [N-1:0] line_q;
   logic [N-1:0] pend_q;

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            line_q[g] <= 1'b0;
            pend_q[g] <= 1'b0;
         end else begin
            line_q[g] <= irq_in[g];
            if (flush)
               pend_q[g] <= 1'b0;
            else if (level_mode)
               pend_q[g] <= irq_in[g];
            else
               pend_q[g] <= (pend_q[g] & ~clr[g]) | (irq_in[g] & ~line_q[g]);
         end
      end

      AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (!level_mode && !flush && pend_q[g] && !clr[g]) |=> pend_q[g]); // R5
      AST_EDGE_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
         (!level_mode && !flush && irq_in[g] && !line_q[g]) |=> pend_q[g]); // R5
   end

   assign pend = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N  = 8,
   parameter int LW = 3
) (
   input  logic [N-1:0]  req,
   input  logic [LW-1:0] low_lvl,
   output logic          any,
   output logic [LW-1:0] lvl,
   output logic [LW-1:0] rank
);
   always_comb begin
      logic [LW-1:0] idx;
      any  = 1'b0;
      lvl  = '0;
      rank = '0;
      for (int k = N - 1; k >= 0; k--) begin
         idx = low_lvl + LW'(1) + LW'(k);
         if (req[idx]) begin
            any  = 1'b1;
            lvl  = idx;
            rank = LW'(k);
         end
      end
   end

   always_comb begin
      if (any) begin
         AST_PICK_VALID: assert (req[lvl]); // R11
      end
   end
endmodule

// File: rtl/irq_prog_regs.sv
module irq_prog_regs
   import irq_prio_pkg::*;
#(
   parameter int N  = 8,
   parameter int LW = 3,
   parameter int DW = 8,
   parameter int BW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          addr0,
   input  logic [DW-1:0] wr_data,
   input  logic          isr_any,
   input  logic [LW-1:0] isr_lvl,
   output logic          level_mode,
   output logic [BW-1:0] vec_base,
   output logic [N-1:0]  mask,
   output logic [LW-1:0] low_lvl,
   output logic          flush,
   output logic [N-1:0]  eoi_clr
);
   if (N != (1 << LW)) begin : g_bad_lines
      $error("line count must equal two to the level width");
   end
   if (N > DW) begin : g_bad_mask
      $error("mask must fit in one data word");
   end
   if (BW + LW > DW) begin : g_bad_base
      $error("base and level must fit in one data word");
   end

   localparam logic [N-1:0] ONE_HOT0 = N'(1);

   cfg_state_e    state_q;
   logic          extra_q;
   logic          op_wr;
   logic [2:0]    op_code;
   logic [LW-1:0] op_lvl;
   logic          tgt_ok;
   logic [LW-1:0] tgt_lvl;

   assign flush   = wr_en && !addr0 && wr_data[4];
   assign op_wr   = wr_en && !addr0 && (wr_data[4:3] == 2'b00);
   assign op_code = wr_data[7:5];
   assign op_lvl  = wr_data[LW-1:0];

   always_comb begin
      tgt_ok  = 1'b0;
      tgt_lvl = op_lvl;
      if (op_wr) begin
         unique case (op_code)
            OP_END_TOP, OP_ROT_END_TOP: begin
               tgt_ok  = isr_any;
               tgt_lvl = isr_lvl;
            end
            OP_END_NAMED, OP_ROT_END_NAME: tgt_ok = 1'b1;
            default: tgt_ok = 1'b0;
         endcase
      end
   end

   assign eoi_clr = tgt_ok ? (ONE_HOT0 << tgt_lvl) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= CFG_READY;
         extra_q    <= 1'b0;
         level_mode <= 1'b0;
         vec_base   <= '0;
         mask       <= '0;
         low_lvl    <= LW'(N - 1);
      end else if (flush) begin
         state_q    <= CFG_WAIT_BASE;
         extra_q    <= wr_data[0];
         level_mode <= wr_data[3];
         mask       <= '0;
         low_lvl    <= LW'(N - 1);
      end else if (wr_en && addr0) begin
         unique case (state_q)
            CFG_WAIT_BASE: begin
               vec_base <= wr_data[DW-1:DW-BW];
               state_q  <= extra_q ? CFG_WAIT_EXTRA : CFG_READY;
            end
            CFG_WAIT_EXTRA: state_q <= CFG_READY;
            default:        mask    <= wr_data[N-1:0];
         endcase
      end else if (op_wr) begin
         if (op_code == OP_SET_BOTTOM || op_code == OP_ROT_END_NAME)
            low_lvl <= op_lvl;
         else if (op_code == OP_ROT_END_TOP && isr_any)
            low_lvl <= isr_lvl;
      end
   end

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr0 && state_q == CFG_READY) |=> (mask == $past(wr_data[N-1:0]))); // R4
   AST_EXTRA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr0 && state_q == CFG_WAIT_EXTRA) |=> ($stable(mask) && $stable(vec_base))); // R4
   AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (mask == '0 && low_lvl == LW'(N - 1))); // R2
   AST_BOTTOM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && op_code == OP_SET_BOTTOM) |=> (low_lvl == $past(op_lvl))); // R10
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int NUM_IRQ = 8,
   parameter int DATA_W  = 8,
   parameter int VEC_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               addr0,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic               ack,
   output logic               int_out,
   output logic [VEC_W-1:0]   vec_out
);
   localparam int LVL_W  = $clog2(NUM_IRQ);
   localparam int BASE_W = VEC_W - LVL_W;
   localparam logic [NUM_IRQ-1:0] ONE_HOT0 = NUM_IRQ'(1);

   if (BASE_W < 1) begin : g_bad_vec
      $error("vector too narrow for the level field");
   end

   logic               level_mode;
   logic [BASE_W-1:0]  vec_base;
   logic [NUM_IRQ-1:0] mask;
   logic [LVL_W-1:0]   low_lvl;
   logic               flush;
   logic [NUM_IRQ-1:0] eoi_clr;
   logic [NUM_IRQ-1:0] pend;
   logic [NUM_IRQ-1:0] live;
   logic [NUM_IRQ-1:0] isr_q;
   logic [NUM_IRQ-1:0] ack_set;
   logic               pend_any, isr_any;
   logic [LVL_W-1:0]   pend_lvl, isr_lvl;
   logic [LVL_W-1:0]   pend_rank, isr_rank;

   irq_prog_regs #(
      .N (NUM_IRQ), .LW(LVL_W), .DW(DATA_W), .BW(BASE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr0     (addr0),
      .wr_data   (wr_data),
      .isr_any   (isr_any),
      .isr_lvl   (isr_lvl),
      .level_mode(level_mode),
      .vec_base  (vec_base),
      .mask      (mask),
      .low_lvl   (low_lvl),
      .flush     (flush),
      .eoi_clr   (eoi_clr)
   );

   irq_req_latch #(.N(NUM_IRQ)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_mode(level_mode),
      .flush     (flush),
      .irq_in    (irq_in),
      .clr       (ack_set),
      .pend      (pend)
   );

   assign live = pend & ~mask;

   irq_prio_pick #(.N(NUM_IRQ), .LW(LVL_W)) u_pick_req (
      .req    (live),
      .low_lvl(low_lvl),
      .any    (pend_any),
      .lvl    (pend_lvl),
      .rank   (pend_rank)
   );

   irq_prio_pick #(.N(NUM_IRQ), .LW(LVL_W)) u_pick_isr (
      .req    (isr_q),
      .low_lvl(low_lvl),
      .any    (isr_any),
      .lvl    (isr_lvl),
      .rank   (isr_rank)
   );

   assign ack_set = (ack && pend_any) ? (ONE_HOT0 << pend_lvl) : '0;
   assign int_out = pend_any && (!isr_any || (pend_rank < isr_rank));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q   <= '0;
         vec_out <= '0;
      end else begin
         if (flush)
            isr_q <= '0;
         else
            isr_q <= (isr_q & ~eoi_clr) | ack_set;
         if (ack)
            vec_out <= {vec_base, (pend_any ? pend_lvl : LVL_W'(NUM_IRQ - 1))};
      end
   end

   AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (live != '0)); // R6
   AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !flush && live != '0) |=> (isr_q != '0)); // R7
   AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && live == '0) |=> (vec_out[LVL_W-1:0] == LVL_W'(NUM_IRQ - 1))); // R7
   AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (vec_out[VEC_W-1:LVL_W] == $past(vec_base))); // R3
   AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_clr != '0 && !ack) |=> ((isr_q & $past(eoi_clr)) == '0)); // R8
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       addr0 = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] irq_in = 8'h00;
   logic       ack = 1'b0;
   logic       int_out;
   logic [7:0] vec_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_prio_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(addr0),
      .wr_data(wr_data), .irq_in(irq_in), .ack(ack),
      .int_out(int_out), .vec_out(vec_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr0 = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; addr0 = 1'b0; wr_data = 8'h00;
   endtask

   task automatic lines(input logic [7:0] v);
      @(negedge clk);
      irq_in = v;
      @(negedge clk);
   endtask

   task automatic pulse(input logic [7:0] v);
      lines(v);
      lines(8'h00);
   endtask

   task automatic do_ack();
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 int after reset", int_out, 0);
      check("R1 vec after reset", vec_out, 0);
      do_ack();
      check("R1 R7 spurious vec base 0", vec_out, 8'h07);
      check("R1 int after spurious", int_out, 0);

      // edge mode, fourth word announced, base 0xA8
      wr(1'b0, 8'h11);
      wr(1'b1, 8'hA8);
      wr(1'b1, 8'hFF);
      pulse(8'h01);
      check("R4 fourth word not a mask", int_out, 1);
      do_ack();
      check("R3 vector base", vec_out, 8'hA8);
      wr(1'b0, 8'h20);
      check("R8 end clears level 0", int_out, 0);

      // sweep over all bottom levels, draining eight requests
      for (int L = 0; L < 8; L++) begin
         wr(1'b0, 8'hC0 | 8'(L));
         lines(8'hFF);
         lines(8'h00);
         check("R5 edge held after fall", int_out, 1);
         for (int k = 0; k < 8; k++) begin
            do_ack();
            check("R11 R7 rotated order vec", vec_out, 8'hA8 | 8'((L + 1 + k) % 8));
            check("R6 lower waits behind service", int_out, 0);
            wr(1'b0, 8'h20);
            check("R8 end releases next", int_out, (k < 7) ? 1 : 0);
         end
      end
      wr(1'b0, 8'hC7);

      // nesting with specific ends
      pulse(8'h20);
      do_ack();
      check("R7 vec 5", vec_out, 8'hAD);
      pulse(8'h40);
      check("R6 level 6 below 5", int_out, 0);
      pulse(8'h04);
      check("R6 level 2 above 5", int_out, 1);
      do_ack();
      check("R7 vec 2", vec_out, 8'hAA);
      check("R6 after nest ack", int_out, 0);
      wr(1'b0, 8'h62);
      check("R9 specific end of 2, 5 still blocks", int_out, 0);
      wr(1'b0, 8'h65);
      check("R9 specific end of 5", int_out, 1);
      do_ack();
      check("R7 vec 6", vec_out, 8'hAE);
      wr(1'b0, 8'h20);
      check("R8 end of 6", int_out, 0);

      // masking
      wr(1'b1, 8'h10);
      pulse(8'h10);
      check("R4 R6 masked line quiet", int_out, 0);
      wr(1'b1, 8'h00);
      check("R4 unmask shows pending", int_out, 1);
      do_ack();
      check("R7 vec 4", vec_out, 8'hAC);
      wr(1'b0, 8'h20);
      check("R8 end of 4", int_out, 0);

      // rotating ends
      pulse(8'h08);
      do_ack();
      check("R7 vec 3", vec_out, 8'hAB);
      wr(1'b0, 8'hA0);
      pulse(8'h12);
      do_ack();
      check("R10 rotate top: 4 now highest", vec_out, 8'hAC);
      check("R6 level 1 below 4", int_out, 0);
      wr(1'b0, 8'hE4);
      check("R10 rotate named end frees 1", int_out, 1);
      do_ack();
      check("R10 vec 1", vec_out, 8'hA9);
      wr(1'b0, 8'h20);
      pulse(8'h81);
      do_ack();
      check("R11 7 outranks 0 with 4 lowest", vec_out, 8'hAF);
      check("R6 0 waits", int_out, 0);
      wr(1'b0, 8'h20);
      do_ack();
      check("R11 vec 0", vec_out, 8'hA8);
      wr(1'b0, 8'h20);
      check("R8 all served", int_out, 0);
      do_ack();
      check("R7 spurious vec", vec_out, 8'hAF);

      // leave level 0 in service and mask all, then set up level mode
      wr(1'b0, 8'hC7);
      pulse(8'h01);
      do_ack();
      wr(1'b1, 8'hFF);
      wr(1'b0, 8'h1A);
      wr(1'b1, 8'h40);
      lines(8'h08);
      check("R2 setup clears mask and service", int_out, 1);
      lines(8'h00);
      check("R5 level mode follows line", int_out, 0);
      lines(8'h08);
      do_ack();
      check("R3 level mode vec", vec_out, 8'h43);
      check("R6 same level not strictly higher", int_out, 0);
      wr(1'b0, 8'h20);
      check("R5 R8 held line requests again", int_out, 1);
      lines(8'h00);
      check("R5 level drop", int_out, 0);
      wr(1'b1, 8'h08);
      lines(8'h08);
      check("R4 no fourth word so mask loads", int_out, 0);
      lines(8'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule